// File: doc/BRIEF.md
# Toggle-Addressed Scan State Array

This block is a square grid of single-bit state cells for random access test. In functional operation every cell loads its bit of a functional data vector on each clock. In test operation one cell at a time is picked by a binary address, and that cell inverts its stored value on the next clock while every other cell keeps its value. Any required test state is therefore reached by toggling only the cells that differ from the current state. No serial shift path and no per-cell mode wire exist: each cell decides what to do only from one row line and one column line, plus the fact that some decoder line is active.

The address is split into a row field and a column field. Each field drives a one-hot decoder whose lines cross the grid. A single enable turns both decoders on. The same pair of lines also gates the selected cell's present value onto a scan-out signal. That signal is built as an OR tree: first within each row, then across the rows. Address bits above the row and column fields must be zero. If any of them is set, no column line rises and the address selects no cell.

Top module: `tras_array`

## Requirements
- R1: While `rst_n` is low, every bit of `state_q` is 0, and `scan_out` stays 0 while `dec_en` is low.
- R2: On each rising clock edge with `dec_en` low, `state_q` takes the value of `func_d`.
- R3: On a rising edge with `dec_en` high and `scan_addr` below SIDE*SIDE, bit `scan_addr` of `state_q` becomes the inverse of its value before that edge.
- R4: During that same edge, every other cell holds its value, whether it shares the row, shares the column or shares neither, and whatever `func_d` carries.
- R5: With `dec_en` high and any `scan_addr` bit at position 2*log2(SIDE) or above set, no bit of `state_q` changes on the edge.
- R6: While `dec_en` is high and the address is in range, `scan_out` equals the current, pre-edge value of `state_q[scan_addr]`.
- R7: `scan_out` is 0 whenever `dec_en` is low or the address is out of range.
- R8: The row index is `scan_addr[2k-1:k]` and the column index is `scan_addr[k-1:0]`, with k = log2(SIDE). The selected cell is bit row*SIDE+col of `state_q` and `func_d`.
- R9: Toggling the same cell on two consecutive test edges restores its original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cells |
| rst_n | input | 1 | Asynchronous active-low clear of all cells |
| func_d | input | SIDE*SIDE | Functional next-state data, one bit per cell |
| scan_addr | input | ADDR_W | Cell address: column field low, row field above it, spare bits on top |
| dec_en | input | 1 | Decoder enable; high selects test operation |
| state_q | output | SIDE*SIDE | Stored state of every cell |
| scan_out | output | 1 | Value of the selected cell, 0 when none is selected |

## Verification
The bench builds the array with SIDE = 4 and ADDR_W = 5. This gives a 16-cell grid and one spare address bit, so out-of-range addresses 16 to 31 can be driven next to every in-range address. At this size the bench can walk a toggle through all sixteen cells, which covers each row and column pairing and cells that share a row or column with the target. It can also repeat a toggle on one cell and switch between capture and toggle edges, checking the whole state vector after every edge.

// File: rtl/tras_pkg.sv
package tras_pkg;

    typedef enum logic [1:0] {
        CELL_CAPTURE = 2'd0,
        CELL_TOGGLE  = 2'd1,
        CELL_HOLD    = 2'd2
    } cell_op_e;

    // Action of one cell from its two crossing lines and the grid-wide
    // indication that some decoder line is active.
    function automatic cell_op_e cell_op(input logic row_hit,
                                         input logic col_hit,
                                         input logic any_line);
        cell_op_e op;
        if (row_hit && col_hit) begin
            op = CELL_TOGGLE;
        end else if (any_line) begin
            op = CELL_HOLD;
        end else begin
            op = CELL_CAPTURE;
        end
        return op;
    endfunction

endpackage

// File: rtl/tras_onehot_dec.sv
module tras_onehot_dec #(
    parameter int IDX_W = 2
) (
    input  logic                 en,
    input  logic [IDX_W-1:0]     idx,
    output logic [(1<<IDX_W)-1:0] lines
);
    localparam int LINES = 1 << IDX_W;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign lines[g] = en && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/tras_cell_grid.sv
module tras_cell_grid
    import tras_pkg::*;
#(
    parameter int SIDE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SIDE-1:0]        row_ln,
    input  logic [SIDE-1:0]        col_ln,
    input  logic [SIDE*SIDE-1:0]   func_d,
    output logic [SIDE*SIDE-1:0]   state_q
);
    localparam int N_CELLS = SIDE * SIDE;

    typedef struct packed {
        logic [N_CELLS-1:0] bits;
    } grid_s;

    grid_s grid_d, grid_q;
    logic  any_line;

    always_comb begin
        any_line = (|row_ln) | (|col_ln);
        grid_d   = grid_q;
        for (int r = 0; r < SIDE; r++) begin
            for (int c = 0; c < SIDE; c++) begin
                unique case (cell_op(row_ln[r], col_ln[c], any_line))
                    CELL_TOGGLE:  grid_d.bits[r*SIDE+c] = ~grid_q.bits[r*SIDE+c];
                    CELL_CAPTURE: grid_d.bits[r*SIDE+c] = func_d[r*SIDE+c];
                    default:      grid_d.bits[r*SIDE+c] = grid_q.bits[r*SIDE+c];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_q <= '0;
        end else begin
            grid_q <= grid_d;
        end
    end

    assign state_q = grid_q.bits;

endmodule

// File: rtl/tras_scanout.sv
module tras_scanout #(
    parameter int SIDE = 4
) (
    input  logic [SIDE-1:0]      row_ln,
    input  logic [SIDE-1:0]      col_ln,
    input  logic [SIDE*SIDE-1:0] state_q,
    output logic                 scan_out
);
    logic [SIDE-1:0] row_bus;

    // First level: each row merges its column-gated cells.
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        assign row_bus[r] = |(state_q[r*SIDE +: SIDE] & col_ln);
    end

    // Second level: the active row line picks one row result.
    assign scan_out = |(row_bus & row_ln);

endmodule

// File: rtl/tras_array.sv
module tras_array #(
    parameter int SIDE   = 4,
    parameter int ADDR_W = $clog2(SIDE * SIDE) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SIDE*SIDE-1:0]   func_d,
    input  logic [ADDR_W-1:0]      scan_addr,
    input  logic                   dec_en,
    output logic [SIDE*SIDE-1:0]   state_q,
    output logic                   scan_out
);
    localparam int SEL_W = $clog2(SIDE);
    localparam int IDX_W = 2 * SEL_W;

    logic            addr_spill;
    logic            col_en;
    logic [SIDE-1:0] row_ln;
    logic [SIDE-1:0] col_ln;

    if (ADDR_W > IDX_W) begin : g_spare
        assign addr_spill = |scan_addr[ADDR_W-1:IDX_W];
    end else begin : g_exact
        assign addr_spill = 1'b0;
    end

    // Out-of-range keeps the row line up (test mode seen by all cells)
    // but drops every column line, so no cell toggles.
    assign col_en = dec_en & ~addr_spill;

    tras_onehot_dec #(.IDX_W(SEL_W)) u_row_dec (
        .en    (dec_en),
        .idx   (scan_addr[IDX_W-1:SEL_W]),
        .lines (row_ln)
    );

    tras_onehot_dec #(.IDX_W(SEL_W)) u_col_dec (
        .en    (col_en),
        .idx   (scan_addr[SEL_W-1:0]),
        .lines (col_ln)
    );

    tras_cell_grid #(.SIDE(SIDE)) u_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_ln  (row_ln),
        .col_ln  (col_ln),
        .func_d  (func_d),
        .state_q (state_q)
    );

    tras_scanout #(.SIDE(SIDE)) u_so (
        .row_ln   (row_ln),
        .col_ln   (col_ln),
        .state_q  (state_q),
        .scan_out (scan_out)
    );

endmodule

// File: rtl/tras_array_chk.sv
module tras_array_chk #(
    parameter int SIDE   = 4,
    parameter int ADDR_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SIDE*SIDE-1:0] func_d,
    input logic [ADDR_W-1:0]    scan_addr,
    input logic                 dec_en,
    input logic [SIDE*SIDE-1:0] state_q,
    input logic                 scan_out
);
    localparam int N_CELLS = SIDE * SIDE;
    localparam int IDX_W   = $clog2(N_CELLS);

    logic             in_rng;
    logic [IDX_W-1:0] cell_idx;

    assign in_rng   = (int'(scan_addr) < N_CELLS);
    assign cell_idx = scan_addr[IDX_W-1:0];

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (state_q == '0));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> (state_q == $past(func_d)));

    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && in_rng) |=> (state_q[$past(cell_idx)] != $past(state_q[cell_idx])));

    a_r4_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> ($countones(state_q ^ $past(state_q)) <= 1));

    a_r5_oor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !in_rng) |=> $stable(state_q));

    a_r6_scan_value: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && in_rng) |-> (scan_out == state_q[cell_idx]));

    a_r7_scan_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_en && in_rng) |-> !scan_out);

endmodule

bind tras_array tras_array_chk #(.SIDE(SIDE), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_d    (func_d),
    .scan_addr (scan_addr),
    .dec_en    (dec_en),
    .state_q   (state_q),
    .scan_out  (scan_out)
);

// File: tb/tras_array_tb.sv
module tras_array_tb;
    localparam int SIDE = 4;
    localparam int AW   = 5;
    localparam int N    = SIDE * SIDE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  func_d = '0;
    logic [AW-1:0] scan_addr = '0;
    logic          dec_en = 1'b0;
    logic [N-1:0]  state_q;
    logic          scan_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    logic [N-1:0] model = '0;

    always #5 clk = ~clk;

    tras_array #(.SIDE(SIDE), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_d    (func_d),
        .scan_addr (scan_addr),
        .dec_en    (dec_en),
        .state_q   (state_q),
        .scan_out  (scan_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of stimulus: checks scan_out before the edge, state after it.
    task automatic step(input logic [N-1:0] f, input int a, input logic en, input string tag);
        logic         exp_so;
        logic [N-1:0] nxt;
        @(negedge clk);
        func_d    = f;
        scan_addr = AW'(a);
        dec_en    = en;
        #1;
        exp_so = 1'b0;
        if (en && a < N) exp_so = model[a];
        chk((en && a < N) ? "R6 scan_out" : "R7 scan_out", 32'(scan_out), 32'(exp_so));
        if (!en) begin
            nxt = f;
        end else if (a < N) begin
            nxt    = model;
            nxt[a] = ~nxt[a];
        end else begin
            nxt = model;
        end
        @(posedge clk);
        #1;
        model = nxt;
        chk(tag, 32'(state_q), 32'(model));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset clears every cell, idle scan_out is 0
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 state", 32'(state_q), 32'h0);
        chk("R1 scan_out", 32'(scan_out), 32'h0);
        rst_n = 1'b1;

        // R2: functional capture under several patterns
        step(16'hA5C3, 0, 1'b0, "R2 capture A5C3");
        step(16'hFFFF, 3, 1'b0, "R2 capture FFFF");
        step(16'h0000, 9, 1'b0, "R2 capture 0000");
        for (int i = 0; i < 4; i++) step(N'($urandom), i, 1'b0, "R2 capture random");

        // R3 / R4: walk a toggle through every cell, functional data opposite
        step(16'h0000, 0, 1'b0, "R2 clear");
        for (int a = 0; a < N; a++) step(~model, a, 1'b1, "R3 R4 toggle walk");
        for (int a = N - 1; a >= 0; a -= 3) step(N'($urandom), a, 1'b1, "R3 R4 toggle back");

        // R8: row 1, column 2 is bit 6; row 2, column 1 is bit 9
        step(16'h0000, 0, 1'b0, "R2 clear");
        step(16'hFFFF, 6, 1'b1, "R8 row1 col2 -> bit6");
        chk("R8 bit6 only", 32'(state_q), 32'h0040);
        step(16'hFFFF, 9, 1'b1, "R8 row2 col1 -> bit9");
        chk("R8 bits 6 and 9", 32'(state_q), 32'h0240);

        // R4: neighbours in same row / column hold against func_d
        step(~model, 10, 1'b1, "R4 same row/col neighbours hold");

        // R9: double toggle restores
        step(16'h1234, 5, 1'b1, "R9 first toggle");
        step(16'h4321, 5, 1'b1, "R9 second toggle");
        chk("R9 restored", 32'(state_q), 32'h0640);

        // R5: out-of-range addresses change nothing
        step(16'hFFFF, 16, 1'b1, "R5 addr 16 holds");
        step(16'h0F0F, 21, 1'b1, "R5 addr 21 holds");
        step(N'($urandom), 31, 1'b1, "R5 addr 31 holds");
        chk("R5 still 0640", 32'(state_q), 32'h0640);

        // R6 / R7 with a mixed state, then back to capture
        step(16'hC3A5, 0, 1'b0, "R2 capture C3A5");
        for (int a = 0; a < N; a += 5) step(N'($urandom), a, 1'b1, "R3 toggle after capture");
        step(16'h5A5A, 2, 1'b0, "R2 capture after test");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule